// File: doc/BRIEF.md
# Memory Read Latency Calibrator

This block learns the read latency of an external memory at run time, instead of relying on a latency fixed at design time. After a start pulse, it waits for the first address strobe. It counts clock cycles until the user returns the matching data-valid strobe, latches that count, and declares itself calibrated. The count then stays fixed until the next start pulse. One value serves the twiddle-factor fetches and the data fetches alike, because both come back together.

Every address strobe, with its address and pass tags, is captured into a delay line from the first address onward. Once the latency is known, the line is tapped at that depth, so each tag leaves the block in the same cycle as the word it belongs to. Addresses issued while the measurement is still running are therefore not lost. The block raises a timeout flag if no word comes back within the supported range. It raises a sticky mismatch flag when, after calibration, a returned strobe disagrees with the prediction made from the delayed address stream.

Top module: `rdlat_calib`

## Requirements
- R1: After reset, the outputs `lat_o`, `cal_o`, `tag_vld_o`, `timeout_o` and `mismatch_o` are all 0. Until the first start pulse, address and return strobes have no effect on any output.
- R2: A start pulse restarts calibration. One cycle later, `lat_o` is 0 and `cal_o`, `timeout_o` and `mismatch_o` are 0. All tags held from before the pulse are discarded. An address strobe in the same cycle as the start pulse is ignored.
- R3: The latency L is measured from the first address strobe after start (cycle t) to the first return strobe (cycle t+L). L lies in the range 1..15. `lat_o` shows L and `cal_o` is 1 from cycle t+L+1 onward.
- R4: A return strobe that arrives after start but before any address strobe has no effect.
- R5: In the cycle of the first return, `tag_vld_o` is 1 and the tag outputs carry the address and pass of the first address strobe.
- R6: Once calibrated, `tag_vld_o`, `tag_addr_o` and `tag_pass_o` in cycle c equal the address strobe, address and pass inputs of cycle c-L. This includes strobes issued during the measurement, and gaps in the address stream are preserved.
- R7: Suppose no return arrives in cycles t+1..t+15. Then `timeout_o` is 1 from cycle t+16 until the next start pulse, `cal_o` stays 0, and `tag_vld_o` stays 0.
- R8: Once calibrated, `mismatch_o` goes to 1 in the cycle after any cycle where `ret_vld_i` differs from the predicted valid. The prediction is `tag_vld_o`, and a mismatch covers both an unexpected return and a missing return. The flag then holds until the next start pulse.
- R9: Once calibrated, `lat_o` and `cal_o` do not change until the next start pulse or reset.

Ports (`LAT_W` = clog2(`MAX_LAT`+1)):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start / restart pulse for calibration |
| addr_vld_i | input | 1 | Address-valid strobe issued to memory |
| addr_i | input | ADDR_W | Address tag travelling with the strobe |
| pass_i | input | PASS_W | Pass tag travelling with the strobe |
| ret_vld_i | input | 1 | Returned data-valid strobe from the user |
| lat_o | output | LAT_W | Latched latency in cycles (0 until calibrated) |
| cal_o | output | 1 | Calibrated flag |
| tag_vld_o | output | 1 | Delayed address strobe, aligned to returned data |
| tag_addr_o | output | ADDR_W | Delayed address tag |
| tag_pass_o | output | PASS_W | Delayed pass tag |
| timeout_o | output | 1 | No return within the latency range |
| mismatch_o | output | 1 | Sticky flag: return strobe disagreed with prediction |

## Verification
The bench tries several address streams. A back-to-back stream at latency 5 exposes off-by-one errors in the tap depth. An alternating stream at latency 1 shows whether gaps survive the delay line, and at the smallest depth. A stream with every third slot empty, at latency 15, tests the deepest tap and the last in-range count. A run that never returns separates the timeout from a late calibration. Other runs add a stray return before any address, a start pulse that coincides with an address, and injected extra and missing returns after calibration. Together these tell a correctly ignored strobe from a mis-measured one, and a sticky mismatch from a transient one.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_MEAS  = 3'd2,
        ST_CAL   = 3'd3,
        ST_TOUT  = 3'd4
    } cal_state_e;

    // States in which address strobes are recorded into the delay line
    function automatic logic capture_on(input cal_state_e s);
        return (s == ST_ARMED) || (s == ST_MEAS) || (s == ST_CAL);
    endfunction

    function automatic int lat_width(input int max_lat);
        return $clog2(max_lat + 1);
    endfunction

endpackage

// File: rtl/rdlat_fsm.sv
module rdlat_fsm
    import rdlat_pkg::*;
#(
    parameter int MAX_LAT = 15,
    localparam int LAT_W  = lat_width(MAX_LAT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             addr_vld,
    input  logic             ret_vld,
    input  logic             exp_vld,
    output cal_state_e       state,
    output logic [LAT_W-1:0] cnt,
    output logic [LAT_W-1:0] lat,
    output logic             mism
);

    localparam logic [LAT_W-1:0] CNT_LIM = LAT_W'(MAX_LAT);
    localparam logic [LAT_W-1:0] CNT_ONE = LAT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            lat   <= '0;
            mism  <= 1'b0;
        end else if (start) begin
            state <= ST_ARMED;
            cnt   <= '0;
            lat   <= '0;
            mism  <= 1'b0;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (addr_vld) begin
                        state <= ST_MEAS;
                        cnt   <= CNT_ONE;
                    end
                end
                ST_MEAS: begin
                    if (ret_vld) begin
                        lat   <= cnt;
                        state <= ST_CAL;
                    end else if (cnt == CNT_LIM) begin
                        state <= ST_TOUT;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                ST_CAL: begin
                    if (ret_vld != exp_vld) mism <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rdlat_tagline.sv
module rdlat_tagline #(
    parameter int DEPTH = 15,
    parameter int W     = 14,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             flush,
    input  logic [W-1:0]     in_d,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     tap_o
);

    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (flush) stage[0] <= '0;
                else       stage[0] <= in_d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (flush) stage[g] <= '0;
                else       stage[g] <= stage[g-1];
            end
        end
    end

    // sel = d selects the word entered d cycles ago; sel = 0 selects nothing
    always_comb begin
        tap_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i + 1)) tap_o = stage[i];
        end
    end

endmodule

// File: rtl/rdlat_calib.sv
module rdlat_calib
    import rdlat_pkg::*;
#(
    parameter int MAX_LAT = 15,
    parameter int ADDR_W  = 10,
    parameter int PASS_W  = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start_i,
    input  logic                                 addr_vld_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [PASS_W-1:0]                    pass_i,
    input  logic                                 ret_vld_i,
    output logic [rdlat_pkg::lat_width(MAX_LAT)-1:0] lat_o,
    output logic                                 cal_o,
    output logic                                 tag_vld_o,
    output logic [ADDR_W-1:0]                    tag_addr_o,
    output logic [PASS_W-1:0]                    tag_pass_o,
    output logic                                 timeout_o,
    output logic                                 mismatch_o
);

    localparam int LAT_W = lat_width(MAX_LAT);
    localparam int TAG_W = 1 + PASS_W + ADDR_W;

    cal_state_e       state;
    logic [LAT_W-1:0] cnt;
    logic [LAT_W-1:0] lat;
    logic             mism;
    logic [LAT_W-1:0] sel;
    logic [TAG_W-1:0] line_in;
    logic [TAG_W-1:0] tap;
    logic             tap_vld;
    logic             cap;

    assign cap     = addr_vld_i & capture_on(state);
    assign line_in = {cap, pass_i, addr_i};
    assign sel     = (state == ST_CAL) ? lat : cnt;
    assign tap_vld = tap[TAG_W-1];

    rdlat_fsm #(.MAX_LAT(MAX_LAT)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .addr_vld (addr_vld_i),
        .ret_vld  (ret_vld_i),
        .exp_vld  (tap_vld),
        .state    (state),
        .cnt      (cnt),
        .lat      (lat),
        .mism     (mism)
    );

    rdlat_tagline #(.DEPTH(MAX_LAT), .W(TAG_W), .SEL_W(LAT_W)) u_line (
        .clk   (clk),
        .flush (rst | start_i),
        .in_d  (line_in),
        .sel   (sel),
        .tap_o (tap)
    );

    always_comb begin
        unique case (state)
            ST_CAL:  tag_vld_o = tap_vld;
            ST_MEAS: tag_vld_o = tap_vld & ret_vld_i;
            default: tag_vld_o = 1'b0;
        endcase
    end

    assign tag_addr_o = tap[ADDR_W-1:0];
    assign tag_pass_o = tap[ADDR_W+PASS_W-1:ADDR_W];
    assign lat_o      = lat;
    assign cal_o      = (state == ST_CAL);
    assign timeout_o  = (state == ST_TOUT);
    assign mismatch_o = mism;

endmodule

// File: rtl/rdlat_calib_sva.sv
module rdlat_calib_sva #(
    parameter int LAT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             ret_vld_i,
    input logic [LAT_W-1:0] lat_o,
    input logic             cal_o,
    input logic             tag_vld_o,
    input logic             timeout_o,
    input logic             mismatch_o
);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!cal_o && !timeout_o && !mismatch_o && lat_o == '0));

    a_r3_cal_after_return: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_o) |-> ($past(ret_vld_i) && lat_o != '0));

    a_r9_lat_held: assert property (@(posedge clk) disable iff (rst)
        (cal_o && !start_i) |=> (cal_o && $stable(lat_o)));

    a_r7_timeout_exclusive: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!cal_o && !tag_vld_o));

    a_r8_mismatch_sticky: assert property (@(posedge clk) disable iff (rst)
        (mismatch_o && !start_i) |=> mismatch_o);

    a_r5_first_tag_on_return: assert property (@(posedge clk) disable iff (rst)
        (tag_vld_o && !cal_o) |-> ret_vld_i);

endmodule

bind rdlat_calib rdlat_calib_sva #(.LAT_W(rdlat_pkg::lat_width(MAX_LAT))) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ret_vld_i  (ret_vld_i),
    .lat_o      (lat_o),
    .cal_o      (cal_o),
    .tag_vld_o  (tag_vld_o),
    .timeout_o  (timeout_o),
    .mismatch_o (mismatch_o)
);

// File: tb/rdlat_calib_tb_top.sv
module rdlat_calib_tb_top;

    localparam int MAX_LAT = 15;
    localparam int ADDR_W  = 10;
    localparam int PASS_W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, addr_vld_i = 1'b0, ret_vld_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [PASS_W-1:0] pass_i = '0;
    logic [3:0] lat_o;
    logic cal_o, tag_vld_o, timeout_o, mismatch_o;
    logic [ADDR_W-1:0] tag_addr_o;
    logic [PASS_W-1:0] tag_pass_o;

    always #2 clk = ~clk;   // 250 MHz

    rdlat_calib #(.MAX_LAT(MAX_LAT), .ADDR_W(ADDR_W), .PASS_W(PASS_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_vld_i(addr_vld_i),
        .addr_i(addr_i), .pass_i(pass_i), .ret_vld_i(ret_vld_i),
        .lat_o(lat_o), .cal_o(cal_o), .tag_vld_o(tag_vld_o),
        .tag_addr_o(tag_addr_o), .tag_pass_o(tag_pass_o),
        .timeout_o(timeout_o), .mismatch_o(mismatch_o)
    );

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference: 0 idle, 1 armed, 2 measuring, 3 calibrated, 4 timed out
    int ms = 0, k = 0, mlat = 0;
    bit mmis = 0;
    bit qv[$];
    int qa[$];
    int qp[$];

    always @(posedge clk) cycles++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic tap(input int d, output bit v, output int a, output int p);
        int n;
        n = qv.size();
        v = 0; a = 0; p = 0;
        if (d >= 1 && n - d >= 0) begin
            v = qv[n-d]; a = qa[n-d]; p = qp[n-d];
        end
    endtask

    // one clock cycle: drive at negedge, compare after settling, advance the model
    task automatic step(input bit s, input bit av, input int ad, input int ps, input bit rv);
        bit tv, ev;
        int ta, tp;
        start_i = s; addr_vld_i = av; addr_i = ADDR_W'(ad); pass_i = PASS_W'(ps); ret_vld_i = rv;
        #1;
        ev = 0; ta = 0; tp = 0;
        if (ms == 3) begin tap(mlat, tv, ta, tp); ev = tv; end
        else if (ms == 2) begin tap(k, tv, ta, tp); ev = tv && rv; end
        chk("R3", "lat_o", int'(lat_o), mlat);
        chk("R9", "cal_o", int'(cal_o), (ms == 3) ? 1 : 0);
        chk("R7", "timeout_o", int'(timeout_o), (ms == 4) ? 1 : 0);
        chk("R8", "mismatch_o", int'(mismatch_o), int'(mmis));
        chk("R6", "tag_vld_o", int'(tag_vld_o), int'(ev));
        if (ev) begin
            chk("R5", "tag_addr_o", int'(tag_addr_o), ta);
            chk("R6", "tag_pass_o", int'(tag_pass_o), tp);
        end
        if (s) begin
            ms = 1; k = 0; mlat = 0; mmis = 0;
            qv.delete(); qa.delete(); qp.delete();
        end else begin
            bit pv;
            int pa, pp;
            tap(mlat, pv, pa, pp);
            case (ms)
                1: if (av) begin ms = 2; k = 1; end
                2: if (rv) begin mlat = k; ms = 3; end
                   else if (k == MAX_LAT) ms = 4;
                   else k++;
                3: if (rv != pv) mmis = 1;
                default: ;
            endcase
            if (ms != 0) begin
                qv.push_back(av && (ms >= 1 && ms <= 3) ? 1'b1 : 1'b0);
                qa.push_back(ad % (1 << ADDR_W));
                qp.push_back(ps % (1 << PASS_W));
            end
        end
        @(negedge clk);
    endtask

    // Start, optional idle lead-in (with a stray return), then an address stream.
    // lat = 0 means memory never answers. flip flips the return at that index.
    task automatic run(input int lat, input int mode, input int pre, input bit stray,
                       input bit start_av, input int flip, input int ncyc);
        bit hist[256];
        step(1'b1, start_av, 999, 7, 1'b0);   // R2: strobe with start is ignored
        for (int i = 0; i < ncyc; i++) begin
            bit av, rv;
            av = 0;
            if (i >= pre && i < ncyc - 20) begin
                case (mode)
                    0: av = 1;
                    1: av = ((i - pre) % 2) == 0;
                    default: av = ((i - pre) % 3) != 1;
                endcase
            end
            hist[i] = av;
            rv = (lat > 0 && i >= lat) ? hist[i-lat] : 1'b0;
            if (stray && i == 1) rv = 1;      // R4: return before any address
            if (i == flip) rv = ~rv;          // R8: injected disagreement
            step(1'b0, av, 3 * i + lat, i + mode, rv);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", "lat_o", int'(lat_o), 0);
        chk("R1", "cal_o", int'(cal_o), 0);
        chk("R1", "timeout_o", int'(timeout_o), 0);
        chk("R1", "tag_vld_o", int'(tag_vld_o), 0);
        chk("R1", "mismatch_o", int'(mismatch_o), 0);
        @(negedge clk);
        rst = 1'b0;
        // R1: strobes before any start do nothing
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i, 1, (i % 2) == 1);
        run(5, 0, 2, 1'b0, 1'b0, -1, 60);   // R3 R5 R6 back-to-back
        run(1, 1, 3, 1'b1, 1'b1, -1, 50);   // R4 R2 alternating, min latency
        run(15, 2, 0, 1'b0, 1'b0, -1, 70);  // max latency, sparse stream
        run(0, 0, 1, 1'b0, 1'b0, -1, 40);   // R7 timeout
        run(3, 0, 0, 1'b0, 1'b0, 30, 50);   // R8 missing return
        run(4, 1, 2, 1'b0, 1'b0, 13, 50);   // R8 unexpected return (gap slot)
        run(7, 2, 0, 1'b0, 1'b0, -1, 60);   // R2 restart clears mismatch, new latency
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, 1'b0);
        done = 1;
        summary();
    end

    initial begin
        wait (cycles > 200000 || done);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            summary();
        end
    end

endmodule